// File: doc/BRIEF.md
# Page Write Staging Buffer

This block gathers the data bytes of one write transaction into a small staging store that spans exactly one page of the array. A transaction opens by loading a starting word address. After that, each accepted data byte is placed at the current in-page offset and marked valid. The offset then advances by one. Only the low offset bits of the address move. The page index stays fixed, so a run of bytes that reaches the end of the page continues at offset zero of the same page. A byte that lands on an offset already filled replaces the earlier byte. When more bytes arrive than the page holds, the store therefore keeps the latest page-worth in arrival order.

When the commit strobe arrives, the block presents to the array, in that same cycle, a write enable together with the page index, a per-byte valid mask and the staged bytes. The valid mask is what keeps locations that were never received untouched. The abort strobe throws the staged bytes away, for example when a new bus Start arrives before the Stop. Bus protocol, protection decisions and array timing all sit outside this block.

Top module: `pgbuf_top`

## Requirements
- R1: After reset, `arr_mask` is all zeros, `arr_we` is low and `nxt_addr` is zero.
- R2: A `start_vld` cycle without `abort` loads `nxt_addr` with `start_addr` and clears `arr_mask` at the next clock edge.
- R3: A `byte_vld` cycle with no other strobe does three things at the next edge. It stores `byte_data` at slot `nxt_addr[3:0]`, which is bits `[8*o+7:8*o]` of `arr_data` for offset o. It sets `arr_mask` bit o. It advances `nxt_addr[3:0]` by one while `nxt_addr[7:4]` stays unchanged.
- R4: The in-page offset wraps from 15 to 0 within the same page. A run that crosses a page boundary never changes the page index.
- R5: When more than 16 bytes are written, each slot holds the most recent byte written to it, and `arr_mask` is all ones.
- R6: In a `commit` cycle without `abort` and with a non-empty mask, `arr_we` is high in that same cycle. `arr_page` shows `nxt_addr[7:4]`, and `arr_mask` and `arr_data` show the staged bytes. In every other cycle `arr_we` is low.
- R7: After a commit, `arr_mask` reads zero from the next edge, and `nxt_addr` keeps its value.
- R8: An `abort` cycle clears `arr_mask`, keeps `arr_we` low and leaves `nxt_addr` unchanged. It also discards any `start_vld`, `byte_vld` or `commit` presented in the same cycle.
- R9: A byte presented in the same cycle as `commit` or `start_vld` is discarded: it is neither stored nor does it advance the offset.
- R10: A `commit` while `arr_mask` is zero leaves `arr_we` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_vld | input | 1 | Load the starting word address and begin a new transaction |
| start_addr | input | 8 | Starting word address: page index in [7:4], offset in [3:0] |
| byte_vld | input | 1 | A data byte is offered this cycle |
| byte_data | input | 8 | Data byte |
| commit | input | 1 | Commit the staged page to the array |
| abort | input | 1 | Discard the staged page |
| arr_we | output | 1 | Array page write enable, same cycle as an accepted commit |
| arr_page | output | 4 | Page index of the staged bytes |
| arr_mask | output | 16 | Per-offset valid mask, bit o for offset o |
| arr_data | output | 128 | Staged bytes, offset o in bits [8*o+7:8*o] |
| nxt_addr | output | 8 | Word address the next accepted byte will use |

## Verification
A wrong offset register shows on `nxt_addr` one edge after the byte. A wrong slot or valid bit stays hidden until the commit cycle, where it appears at once as a mismatched `arr_mask` bit or a byte in the wrong lane of `arr_data`. For that reason every start offset is swept with run lengths from a single byte up past two full wraps, and each commit compares all sixteen lanes. A mask that fails to clear shows on the next idle cycle. It also shows as a spurious `arr_we` on an empty commit.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;

  // Per-cycle control derived from the four input strobes.
  typedef struct packed {
    logic load;   // take a new starting address
    logic clr;    // drop every valid bit
    logic wr;     // store the offered byte
    logic fire;   // present the page to the array
  } pgb_ctl_t;

  // Priority: abort over everything; start and commit both clear the
  // staged bytes; a byte is taken only on a cycle with no other strobe.
  function automatic pgb_ctl_t pgb_decode(input logic abort_i,
                                          input logic start_i,
                                          input logic commit_i,
                                          input logic byte_i);
    pgb_ctl_t c;
    c.load = !abort_i && start_i;
    c.fire = !abort_i && commit_i;
    c.clr  = abort_i || start_i || commit_i;
    c.wr   = !abort_i && !start_i && !commit_i && byte_i;
    return c;
  endfunction

endpackage

// File: rtl/pgb_rst_sync.sv
module pgb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/pgb_ptr.sv
module pgb_ptr #(
  parameter int ADDR_W = 8,
  parameter int OFS_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [ADDR_W-1:0]       load_addr,
  input  logic                    adv,
  output logic [ADDR_W-OFS_W-1:0] page_q,
  output logic [OFS_W-1:0]        ofs_q
);

  localparam int PAGE_W = ADDR_W - OFS_W;

  logic [PAGE_W-1:0] page_d;
  logic [OFS_W-1:0]  ofs_d;
  logic              en;

  // Only the offset counts; it rolls over inside the page by its width.
  always_comb begin
    en     = load || adv;
    page_d = page_q;
    ofs_d  = ofs_q + 1'b1;
    if (load) begin
      page_d = load_addr[ADDR_W-1:OFS_W];
      ofs_d  = load_addr[OFS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      ofs_q  <= '0;
    end else if (en) begin
      page_q <= page_d;
      ofs_q  <= ofs_d;
    end
  end

endmodule

// File: rtl/pgb_slots.sv
module pgb_slots #(
  parameter int OFS_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic                           wr,
  input  logic [OFS_W-1:0]               wr_ofs,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [(1<<OFS_W)-1:0]          mask_q,
  output logic [(1<<OFS_W)*DATA_W-1:0]   data_q
);

  localparam int SLOTS = 1 << OFS_W;

  logic              vld_q  [SLOTS];
  logic [DATA_W-1:0] byte_q [SLOTS];

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    logic hit;
    logic vld_d;

    always_comb begin
      hit   = wr && (wr_ofs == OFS_W'(gi));
      vld_d = vld_q[gi];
      if (clr) begin
        vld_d = 1'b0;
      end else if (hit) begin
        vld_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[gi] <= 1'b0;
      end else begin
        vld_q[gi] <= vld_d;
      end
    end

    // Data storage carries no reset; the valid bit qualifies it.
    always_ff @(posedge clk) begin
      if (hit) begin
        byte_q[gi] <= wr_data;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      mask_q[i]                   = vld_q[i];
      data_q[i*DATA_W +: DATA_W]  = byte_q[i];
    end
  end

endmodule

// File: rtl/pgbuf_top.sv
module pgbuf_top #(
  parameter int ADDR_W = 8,
  parameter int OFS_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_vld,
  input  logic [ADDR_W-1:0]            start_addr,
  input  logic                         byte_vld,
  input  logic [DATA_W-1:0]            byte_data,
  input  logic                         commit,
  input  logic                         abort,
  output logic                         arr_we,
  output logic [ADDR_W-OFS_W-1:0]      arr_page,
  output logic [(1<<OFS_W)-1:0]        arr_mask,
  output logic [(1<<OFS_W)*DATA_W-1:0] arr_data,
  output logic [ADDR_W-1:0]            nxt_addr
);

  import pgbuf_pkg::*;

  localparam int SLOTS  = 1 << OFS_W;
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic              rst_n_int;
  pgb_ctl_t          ctl;
  logic [PAGE_W-1:0] page_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [SLOTS-1:0]  mask_q;

  pgb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  always_comb begin
    ctl = pgb_decode(abort, start_vld, commit, byte_vld);
  end

  pgb_ptr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .load      (ctl.load),
    .load_addr (start_addr),
    .adv       (ctl.wr),
    .page_q    (page_q),
    .ofs_q     (ofs_q)
  );

  pgb_slots #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .clr     (ctl.clr),
    .wr      (ctl.wr),
    .wr_ofs  (ofs_q),
    .wr_data (byte_data),
    .mask_q  (mask_q),
    .data_q  (arr_data)
  );

  // The page is presented in the commit cycle itself; the mask is
  // cleared at the edge that closes it.
  assign arr_we   = ctl.fire && (|mask_q);
  assign arr_page = page_q;
  assign arr_mask = mask_q;
  assign nxt_addr = {page_q, ofs_q};

endmodule

// File: rtl/pgbuf_chk.sv
module pgbuf_chk #(
  parameter int ADDR_W = 8,
  parameter int OFS_W  = 4,
  parameter int DATA_W = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         start_vld,
  input logic [ADDR_W-1:0]            start_addr,
  input logic                         byte_vld,
  input logic [DATA_W-1:0]            byte_data,
  input logic                         commit,
  input logic                         abort,
  input logic                         arr_we,
  input logic [ADDR_W-OFS_W-1:0]      arr_page,
  input logic [(1<<OFS_W)-1:0]        arr_mask,
  input logic [(1<<OFS_W)*DATA_W-1:0] arr_data,
  input logic [ADDR_W-1:0]            nxt_addr
);

  logic take_byte;
  logic idle;
  assign take_byte = byte_vld && !abort && !start_vld && !commit;
  assign idle      = !byte_vld && !abort && !start_vld && !commit;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_vld && !abort) |=> (nxt_addr == $past(start_addr)) && (arr_mask == '0));

  // R3 and R4: offset steps by one modulo the page, page index held.
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_byte |=> (nxt_addr[OFS_W-1:0] == $past(nxt_addr[OFS_W-1:0]) + 1'b1)
               && (nxt_addr[ADDR_W-1:OFS_W] == $past(nxt_addr[ADDR_W-1:OFS_W]))
               && arr_mask[$past(nxt_addr[OFS_W-1:0])]);

  p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> commit && !abort && (arr_mask != '0));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (commit || abort) |=> (arr_mask == '0));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> $stable(nxt_addr));

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(arr_mask) && $stable(nxt_addr));

endmodule

bind pgbuf_top pgbuf_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_vld  (start_vld),
  .start_addr (start_addr),
  .byte_vld   (byte_vld),
  .byte_data  (byte_data),
  .commit     (commit),
  .abort      (abort),
  .arr_we     (arr_we),
  .arr_page   (arr_page),
  .arr_mask   (arr_mask),
  .arr_data   (arr_data),
  .nxt_addr   (nxt_addr)
);

// File: tb/tb_pgbuf_top.sv
module tb_pgbuf_top;

  logic         clk;
  logic         rst_n;
  logic         start_vld;
  logic [7:0]   start_addr;
  logic         byte_vld;
  logic [7:0]   byte_data;
  logic         commit;
  logic         abort;
  logic         arr_we;
  logic [3:0]   arr_page;
  logic [15:0]  arr_mask;
  logic [127:0] arr_data;
  logic [7:0]   nxt_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  pgbuf_top dut (
    .clk(clk), .rst_n(rst_n), .start_vld(start_vld), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .commit(commit), .abort(abort),
    .arr_we(arr_we), .arr_page(arr_page), .arr_mask(arr_mask),
    .arr_data(arr_data), .nxt_addr(nxt_addr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_strobes();
    start_vld = 0; byte_vld = 0; commit = 0; abort = 0;
  endtask

  task automatic do_start(input logic [7:0] a);
    start_vld = 1; start_addr = a;
    @(negedge clk);
    idle_strobes();
  endtask

  task automatic do_byte(input logic [7:0] d);
    byte_vld = 1; byte_data = d;
    @(negedge clk);
    idle_strobes();
  endtask

  function automatic logic [7:0] pat(input int s, input int n, input int k);
    return 8'(s * 37 + k * 11 + n * 5 + 3);
  endfunction

  // Index of the last byte of a run that lands on slot j, or -1.
  function automatic int last_k(input int s, input int n, input int j);
    int rel;
    rel = (j - s + 16) % 16;
    if (rel >= n) return -1;
    return rel + 16 * ((n - 1 - rel) / 16);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_addr = 0; byte_data = 0;
    idle_strobes();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #5;
    chk(arr_mask == 0, "R1 mask", 128'(arr_mask), 0);
    chk(arr_we == 0,   "R1 we",   128'(arr_we),   0);
    chk(nxt_addr == 0, "R1 addr", 128'(nxt_addr), 0);
    repeat (3) @(negedge clk);

    // R10: commit on an empty buffer
    commit = 1; #5;
    chk(arr_we == 0, "R10 empty commit", 128'(arr_we), 0);
    @(negedge clk); idle_strobes();

    // R8: abort overrides every other strobe
    do_start(8'h32); do_byte(8'hAA); do_byte(8'hBB);
    abort = 1; start_vld = 1; start_addr = 8'h77; byte_vld = 1; byte_data = 8'hCC; commit = 1;
    #5;
    chk(arr_we == 0, "R8 we", 128'(arr_we), 0);
    @(negedge clk); idle_strobes();
    chk(arr_mask == 0,     "R8 mask", 128'(arr_mask), 0);
    chk(nxt_addr == 8'h34, "R8 addr", 128'(nxt_addr), 128'h34);

    // R9: byte with commit is dropped
    do_start(8'h50); do_byte(8'h11);
    commit = 1; byte_vld = 1; byte_data = 8'h22;
    #5;
    chk(arr_we == 1,        "R9 we",   128'(arr_we),   1);
    chk(arr_mask == 16'h1,  "R9 mask", 128'(arr_mask), 1);
    chk(arr_data[7:0] == 8'h11, "R9 data", 128'(arr_data[7:0]), 128'h11);
    @(negedge clk); idle_strobes();
    chk(nxt_addr == 8'h51, "R9 addr", 128'(nxt_addr), 128'h51);
    commit = 1; #5;
    chk(arr_we == 0, "R9 no leftover", 128'(arr_we), 0);
    @(negedge clk); idle_strobes();

    // R9: byte with start is dropped
    do_start(8'h60); do_byte(8'h33);
    start_vld = 1; start_addr = 8'h9C; byte_vld = 1; byte_data = 8'h44;
    @(negedge clk); idle_strobes();
    chk(nxt_addr == 8'h9C, "R9 start addr", 128'(nxt_addr), 128'h9C);
    chk(arr_mask == 0,     "R2 start clears", 128'(arr_mask), 0);

    // Sweep: every start offset, run lengths 1..21 and 33
    for (int s = 0; s < 16; s++) begin
      for (int n = 1; n <= 22; n++) begin
        int len;
        logic [3:0] p;
        logic [15:0] em;
        len = (n == 22) ? 33 : n;
        p = 4'((s * 3 + len) % 16);
        do_start({p, 4'(s)});
        chk(nxt_addr == {p, 4'(s)}, "R2 load", 128'(nxt_addr), 128'({p, 4'(s)}));
        for (int k = 0; k < len; k++) begin
          logic [7:0] ea;
          do_byte(pat(s, len, k));
          ea = {p, 4'((s + k + 1) % 16)};
          if (((s + k + 1) % 16) == 0)
            chk(nxt_addr == ea, "R4 wrap", 128'(nxt_addr), 128'(ea));
          else
            chk(nxt_addr == ea, "R3 step", 128'(nxt_addr), 128'(ea));
        end
        em = 0;
        for (int j = 0; j < 16; j++) if (last_k(s, len, j) >= 0) em[j] = 1'b1;
        if (len >= 16)
          chk(arr_mask == 16'hFFFF, "R5 full mask", 128'(arr_mask), 128'hFFFF);
        commit = 1; #5;
        chk(arr_we == 1,   "R6 we",   128'(arr_we),   1);
        chk(arr_page == p, "R6 page", 128'(arr_page), 128'(p));
        chk(arr_mask == em, "R6 mask", 128'(arr_mask), 128'(em));
        for (int j = 0; j < 16; j++) begin
          int lk;
          lk = last_k(s, len, j);
          if (lk >= 0) begin
            if (len > 16)
              chk(arr_data[j*8 +: 8] == pat(s, len, lk), "R5 overwrite",
                  128'(arr_data[j*8 +: 8]), 128'(pat(s, len, lk)));
            else
              chk(arr_data[j*8 +: 8] == pat(s, len, lk), "R3 slot data",
                  128'(arr_data[j*8 +: 8]), 128'(pat(s, len, lk)));
          end
        end
        @(negedge clk); idle_strobes();
        chk(arr_mask == 0, "R7 mask clear", 128'(arr_mask), 0);
        chk(nxt_addr == {p, 4'((s + len) % 16)}, "R7 addr kept",
            128'(nxt_addr), 128'({p, 4'((s + len) % 16)}));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule